// File: doc/BRIEF.md
# Single-Precision Last-Place Step Unit

This block provides the small primitives that interval arithmetic needs to widen or tighten a bound by exactly one representable step. It takes one binary32 operand and an operation code. It returns one of the following:

- the weight of the operand's last mantissa place, or half that weight;
- the operand moved to the next representable neighbour, either toward zero, away from zero, toward positive infinity or toward negative infinity;
- one of three sign-bit manipulations that use a second operand.

All results are bit-exact. The unit never rounds, because every result is either representable or fixed by a stated rule.

Operands enter on a valid/ready stream and results leave on a second valid/ready stream. The result is registered, so it appears on the output the cycle after the input is accepted. The unit holds one result.

- `in_ready` is high whenever the output register is empty, or is being drained in the same cycle (`out_ready` high).
- While `out_valid` is high and `out_ready` is low, the result and `out_valid` stay frozen and no new operand is taken.
- With `out_ready` held high, the unit accepts an operand every cycle.

Top module: `fp_step_unit`

## Requirements
- R1: Opcode 0 (last-place weight) on a finite nonzero operand with biased exponent e returns the value 2^(e-150), or 2^-149 when e is 0. The sign is the operand's. The result is normal with exponent field e-23 when e > 23, otherwise the subnormal with only mantissa bit e-1 set (bit 0 when e is 0).
- R2: Opcode 0 on +0 or -0 returns the smallest subnormal (magnitude bits 0x00000001) of the same sign. On an infinity it returns the operand unchanged.
- R3: Opcode 1 (half weight) returns half of the opcode 0 magnitude with the same sign. When that half is not representable (exponent field 0 or 1, or a zero operand), it returns a zero of the operand's sign. An infinity is returned unchanged.
- R4: Opcode 2 (step toward zero) subtracts one from the 31-bit magnitude field, borrowing from the exponent, so a result may become subnormal and ±0x00000001 becomes ±0. Zeros and infinities pass unchanged.
- R5: Opcode 3 (step away from zero) adds one to the magnitude field, carrying into the exponent. ±0 becomes ±smallest subnormal, ±largest finite (0x7F7FFFFF magnitude) becomes ±infinity, and infinities pass unchanged.
- R6: Opcode 4 steps toward +infinity and opcode 5 steps toward -infinity. The direction follows from the sign bit: positive operands use the away step for opcode 4 and the toward-zero step for opcode 5, negative operands the reverse. Either zero goes to +smallest subnormal under opcode 4 and to -smallest subnormal under opcode 5.
- R7: For opcodes 0 to 5, a NaN operand (exponent all ones, mantissa nonzero) is returned bit for bit.
- R8: Opcode 6 returns 1 when bit 31 of the first operand is set and 0 otherwise, so -0 reports 1.
- R9: Opcode 7 returns the first operand with its sign bit XORed with bit 31 of the second operand. Opcode 8 returns the first operand with bit 31 replaced by bit 31 of the second operand.
- R10: A result appears on `out_data` with `out_valid` high in the cycle after the operand is accepted. While `out_ready` is low and `out_valid` is high, `out_data` and `out_valid` hold and `in_ready` is low.
- R11: Opcodes 9 to 15 return all zeros.
- R12: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand and opcode present |
| in_ready | output | 1 | Unit can take an operand this cycle |
| in_a | input | 32 | Main binary32 operand |
| in_b | input | 32 | Second operand, read only by the sign operations |
| in_op | input | 4 | Operation code |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 32 | Registered result |

## Verification
The step and weight operations are driven with operand classes chosen to isolate each boundary:

- normal numbers with zero and all-ones mantissas, which tell a plain magnitude change from one that carries or borrows across the exponent;
- the largest finite value, which separates correct overflow to infinity from wrap-around;
- exponent fields of 0, 1 and 10, which tell the subnormal placement of the last-place weight from the normal encoding and expose the unrepresentable half weight;
- both signed zeros and both infinities, which show that the directed steps pick their direction from the sign bit and that the fixed rules win over arithmetic;
- quiet NaNs of both signs, which must come back untouched.

A stall sequence with a second operand waiting shows that back-pressure freezes the result and that the waiting operand is taken in the cycle ready returns.

// File: rtl/fsu_pkg.sv
package fsu_pkg;

  localparam int FSU_EXP_W = 8;
  localparam int FSU_MAN_W = 23;
  localparam int FSU_W     = 1 + FSU_EXP_W + FSU_MAN_W;

  typedef enum logic [3:0] {
    OP_ULP       = 4'd0,
    OP_HALF_ULP  = 4'd1,
    OP_STEP_IN   = 4'd2,
    OP_STEP_OUT  = 4'd3,
    OP_STEP_UP   = 4'd4,
    OP_STEP_DOWN = 4'd5,
    OP_SIGN_GET  = 4'd6,
    OP_SIGN_XOR  = 4'd7,
    OP_SIGN_COPY = 4'd8
  } fsu_op_e;

  typedef struct packed {
    logic is_zero;
    logic is_sub;
    logic is_inf;
    logic is_nan;
  } fsu_class_t;

endpackage

// File: rtl/fsu_classify.sv
module fsu_classify
  import fsu_pkg::*;
#(
  parameter int EXP_W = FSU_EXP_W,
  parameter int MAN_W = FSU_MAN_W,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] val,
  output fsu_class_t   cls
);

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_max;
  logic             exp_min;
  logic             man_nz;

  assign exp_f   = val[MAN_W +: EXP_W];
  assign man_f   = val[MAN_W-1:0];
  assign exp_max = &exp_f;
  assign exp_min = ~|exp_f;
  assign man_nz  = |man_f;

  always_comb begin
    cls.is_zero = exp_min & ~man_nz;
    cls.is_sub  = exp_min &  man_nz;
    cls.is_inf  = exp_max & ~man_nz;
    cls.is_nan  = exp_max &  man_nz;
  end

endmodule

// File: rtl/fsu_ulp.sv
module fsu_ulp
  import fsu_pkg::*;
#(
  parameter int EXP_W = FSU_EXP_W,
  parameter int MAN_W = FSU_MAN_W,
  localparam int W = 1 + EXP_W + MAN_W,
  localparam int MAG_W = EXP_W + MAN_W
) (
  input  logic [W-1:0] val,
  input  fsu_class_t   cls,
  output logic [W-1:0] ulp,
  output logic [W-1:0] half
);

  localparam logic [EXP_W-1:0] MAN_E  = EXP_W'(MAN_W);
  localparam logic [EXP_W-1:0] MAN_E1 = EXP_W'(MAN_W + 1);
  localparam logic [EXP_W-1:0] E_ONE  = EXP_W'(1);
  localparam logic [EXP_W-1:0] E_TWO  = EXP_W'(2);
  localparam logic [MAG_W-1:0] M_ONE  = MAG_W'(1);

  logic             sgn;
  logic [EXP_W-1:0] e;
  logic [MAG_W-1:0] ulp_mag;
  logic [MAG_W-1:0] half_mag;

  assign sgn = val[W-1];
  assign e   = val[MAN_W +: EXP_W];

  // Magnitude of the last-place weight.
  always_comb begin
    if (e == '0) begin
      ulp_mag = M_ONE;
    end else if (e > MAN_E) begin
      ulp_mag = {e - MAN_E, {MAN_W{1'b0}}};
    end else begin
      ulp_mag = M_ONE << (e - E_ONE);
    end
  end

  // Half of that weight; the lowest two binades cannot hold it.
  always_comb begin
    if (e <= E_ONE) begin
      half_mag = '0;
    end else if (e > MAN_E1) begin
      half_mag = {e - MAN_E1, {MAN_W{1'b0}}};
    end else begin
      half_mag = M_ONE << (e - E_TWO);
    end
  end

  always_comb begin
    if (cls.is_inf || cls.is_nan) begin
      ulp  = val;
      half = val;
    end else begin
      ulp  = {sgn, ulp_mag};
      half = {sgn, half_mag};
    end
  end

endmodule

// File: rtl/fsu_nudge.sv
module fsu_nudge
  import fsu_pkg::*;
#(
  parameter int EXP_W = FSU_EXP_W,
  parameter int MAN_W = FSU_MAN_W,
  localparam int W = 1 + EXP_W + MAN_W,
  localparam int MAG_W = EXP_W + MAN_W
) (
  input  logic [W-1:0] val,
  input  fsu_class_t   cls,
  output logic [W-1:0] step_in,
  output logic [W-1:0] step_out,
  output logic [W-1:0] step_up,
  output logic [W-1:0] step_down
);

  localparam logic [MAG_W-1:0] M_ONE = MAG_W'(1);

  logic             sgn;
  logic [MAG_W-1:0] mag;
  logic [MAG_W-1:0] mag_dec;
  logic [MAG_W-1:0] mag_inc;

  assign sgn     = val[W-1];
  assign mag     = val[MAG_W-1:0];
  assign mag_dec = mag - M_ONE;
  assign mag_inc = mag + M_ONE;

  always_comb begin
    if (cls.is_zero || cls.is_inf || cls.is_nan) step_in = val;
    else                                         step_in = {sgn, mag_dec};

    if (cls.is_inf || cls.is_nan) step_out = val;
    else                          step_out = {sgn, mag_inc};

    if (cls.is_nan)       step_up = val;
    else if (cls.is_zero) step_up = {1'b0, M_ONE};
    else if (sgn)         step_up = step_in;
    else                  step_up = step_out;

    if (cls.is_nan)       step_down = val;
    else if (cls.is_zero) step_down = {1'b1, M_ONE};
    else if (sgn)         step_down = step_out;
    else                  step_down = step_in;
  end

endmodule

// File: rtl/fsu_sign.sv
module fsu_sign
  import fsu_pkg::*;
#(
  parameter int EXP_W = FSU_EXP_W,
  parameter int MAN_W = FSU_MAN_W,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sign_get,
  output logic [W-1:0] sign_xor,
  output logic [W-1:0] sign_copy
);

  assign sign_get  = {{(W-1){1'b0}}, a[W-1]};
  assign sign_xor  = {a[W-1] ^ b[W-1], a[W-2:0]};
  assign sign_copy = {b[W-1], a[W-2:0]};

endmodule

// File: rtl/fp_step_unit.sv
module fp_step_unit
  import fsu_pkg::*;
#(
  parameter int EXP_W = FSU_EXP_W,
  parameter int MAN_W = FSU_MAN_W,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [3:0]   in_op,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  fsu_class_t   a_cls;
  logic [W-1:0] r_ulp, r_half;
  logic [W-1:0] r_in, r_out, r_up, r_down;
  logic [W-1:0] r_get, r_xor, r_copy;
  logic [W-1:0] result;
  logic         accept;

  fsu_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
    .val (in_a),
    .cls (a_cls)
  );

  fsu_ulp #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_ulp (
    .val  (in_a),
    .cls  (a_cls),
    .ulp  (r_ulp),
    .half (r_half)
  );

  fsu_nudge #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_nudge (
    .val       (in_a),
    .cls       (a_cls),
    .step_in   (r_in),
    .step_out  (r_out),
    .step_up   (r_up),
    .step_down (r_down)
  );

  fsu_sign #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_sign (
    .a         (in_a),
    .b         (in_b),
    .sign_get  (r_get),
    .sign_xor  (r_xor),
    .sign_copy (r_copy)
  );

  always_comb begin
    case (in_op)
      OP_ULP:       result = r_ulp;
      OP_HALF_ULP:  result = r_half;
      OP_STEP_IN:   result = r_in;
      OP_STEP_OUT:  result = r_out;
      OP_STEP_UP:   result = r_up;
      OP_STEP_DOWN: result = r_down;
      OP_SIGN_GET:  result = r_get;
      OP_SIGN_XOR:  result = r_xor;
      OP_SIGN_COPY: result = r_copy;
      default:      result = '0;
    endcase
  end

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= result;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/fsu_checker.sv
module fsu_checker
  import fsu_pkg::*;
#(
  parameter int EXP_W = FSU_EXP_W,
  parameter int MAN_W = FSU_MAN_W,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic [3:0]   in_op,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data
);

  logic take;
  logic a_special;
  logic a_nan;

  assign take      = in_valid & in_ready;
  assign a_special = &in_a[MAN_W +: EXP_W];
  assign a_nan     = a_special & (|in_a[MAN_W-1:0]);

  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid); // R10

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R10

  AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R10

  AST_STEP_OUT_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_op == 4'd3 && !a_special) |=>
      (out_data[W-2:0] == $past(in_a[W-2:0]) + 1'b1)); // R5

  AST_STEP_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (in_op == 4'd2 || in_op == 4'd3 || in_op == 4'd0)) |=>
      (out_data[W-1] == $past(in_a[W-1]))); // R4

  AST_NAN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && a_nan && in_op <= 4'd5) |=> (out_data == $past(in_a))); // R7

  AST_SIGN_GET_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_op == 4'd6) |=>
      (out_data[W-1:1] == '0 && out_data[0] == $past(in_a[W-1]))); // R8

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_op >= 4'd9) |=> (out_data == '0)); // R11

endmodule

bind fp_step_unit fsu_checker #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_fsu_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_a      (in_a),
  .in_b      (in_b),
  .in_op     (in_op),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/tb_fp_step_unit.sv
module tb_fp_step_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic [3:0]  in_op = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_step_unit dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_a      (in_a),
    .in_b      (in_b),
    .in_op     (in_op),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present one operand, then sample the registered result one cycle later.
  task automatic op_check(input string req, input logic [3:0] op,
                          input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] exp);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, {31'b0, out_valid}, 32'd1);
    chk(req, out_data, exp);
  endtask

  task automatic t_reset;
    chk("R12 out_valid", {31'b0, out_valid}, 32'd0);
    chk("R12 in_ready",  {31'b0, in_ready},  32'd1);
  endtask

  task automatic t_ulp;
    op_check("R1 one",      4'd0, 32'h3F800000, '0, 32'h34000000);
    op_check("R1 neg",      4'd0, 32'hBFC00000, '0, 32'hB4000000);
    op_check("R1 low exp",  4'd0, 32'h05000000, '0, 32'h00000200);
    op_check("R1 subnorm",  4'd0, 32'h00000123, '0, 32'h00000001);
    op_check("R1 max",      4'd0, 32'h7F7FFFFF, '0, 32'h73800000);
    op_check("R2 pzero",    4'd0, 32'h00000000, '0, 32'h00000001);
    op_check("R2 nzero",    4'd0, 32'h80000000, '0, 32'h80000001);
    op_check("R2 ninf",     4'd0, 32'hFF800000, '0, 32'hFF800000);
  endtask

  task automatic t_half;
    op_check("R3 one",      4'd1, 32'h3F800000, '0, 32'h33800000);
    op_check("R3 low exp",  4'd1, 32'h05000000, '0, 32'h00000100);
    op_check("R3 e24",      4'd1, 32'h0C000000, '0, 32'h00400000);
    op_check("R3 e1",       4'd1, 32'h00800000, '0, 32'h00000000);
    op_check("R3 nsub",     4'd1, 32'h80000123, '0, 32'h80000000);
    op_check("R3 nzero",    4'd1, 32'h80000000, '0, 32'h80000000);
    op_check("R3 pinf",     4'd1, 32'h7F800000, '0, 32'h7F800000);
  endtask

  task automatic t_step_in;
    op_check("R4 one",      4'd2, 32'h3F800000, '0, 32'h3F7FFFFF);
    op_check("R4 to sub",   4'd2, 32'h00800000, '0, 32'h007FFFFF);
    op_check("R4 min sub",  4'd2, 32'h80000001, '0, 32'h80000000);
    op_check("R4 zero",     4'd2, 32'h00000000, '0, 32'h00000000);
    op_check("R4 ninf",     4'd2, 32'hFF800000, '0, 32'hFF800000);
  endtask

  task automatic t_step_out;
    op_check("R5 carry",    4'd3, 32'h3F7FFFFF, '0, 32'h3F800000);
    op_check("R5 max",      4'd3, 32'h7F7FFFFF, '0, 32'h7F800000);
    op_check("R5 nmax",     4'd3, 32'hFF7FFFFF, '0, 32'hFF800000);
    op_check("R5 nzero",    4'd3, 32'h80000000, '0, 32'h80000001);
    op_check("R5 pinf",     4'd3, 32'h7F800000, '0, 32'h7F800000);
  endtask

  task automatic t_directed;
    op_check("R6 up neg",   4'd4, 32'hBF800000, '0, 32'hBF7FFFFF);
    op_check("R6 up pos",   4'd4, 32'h3F800000, '0, 32'h3F800001);
    op_check("R6 up nzero", 4'd4, 32'h80000000, '0, 32'h00000001);
    op_check("R6 up pzero", 4'd4, 32'h00000000, '0, 32'h00000001);
    op_check("R6 up ninf",  4'd4, 32'hFF800000, '0, 32'hFF800000);
    op_check("R6 up nmax",  4'd4, 32'hFF7FFFFF, '0, 32'hFF7FFFFE);
    op_check("R6 dn pos",   4'd5, 32'h3F800000, '0, 32'h3F7FFFFF);
    op_check("R6 dn neg",   4'd5, 32'hBF800000, '0, 32'hBF800001);
    op_check("R6 dn pzero", 4'd5, 32'h00000000, '0, 32'h80000001);
    op_check("R6 dn nzero", 4'd5, 32'h80000000, '0, 32'h80000001);
    op_check("R6 dn pinf",  4'd5, 32'h7F800000, '0, 32'h7F800000);
  endtask

  task automatic t_nan;
    for (int op = 0; op < 6; op++) begin
      op_check("R7 qnan", 4'(op), 32'h7FC00001, '0, 32'h7FC00001);
      op_check("R7 nnan", 4'(op), 32'hFFC00000, '0, 32'hFFC00000);
    end
  endtask

  task automatic t_sign;
    op_check("R8 nzero",    4'd6, 32'h80000000, '0, 32'h00000001);
    op_check("R8 pzero",    4'd6, 32'h00000000, '0, 32'h00000000);
    op_check("R8 neg",      4'd6, 32'hBF800000, '0, 32'h00000001);
    op_check("R9 xor set",  4'd7, 32'h3F800000, 32'h80000000, 32'hBF800000);
    op_check("R9 xor clr",  4'd7, 32'hBF800000, 32'hC0000000, 32'h3F800000);
    op_check("R9 xor keep", 4'd7, 32'hBF800000, 32'h40000000, 32'hBF800000);
    op_check("R9 copy pos", 4'd8, 32'hBF800000, 32'h00000000, 32'h3F800000);
    op_check("R9 copy neg", 4'd8, 32'h3F800000, 32'h80000000, 32'hBF800000);
  endtask

  task automatic t_reserved;
    op_check("R11 op9",  4'd9,  32'h3F800000, 32'hFFFFFFFF, 32'h00000000);
    op_check("R11 op15", 4'd15, 32'hBF800000, 32'hFFFFFFFF, 32'h00000000);
  endtask

  task automatic t_handshake;
    // Single result drops after one cycle with the consumer ready.
    op_check("R10 latency", 4'd3, 32'h00000000, '0, 32'h00000001);
    @(negedge clk);
    chk("R10 one cycle", {31'b0, out_valid}, 32'd0);
    // Stall: result must hold while another operand waits.
    out_ready = 1'b0;
    op_check("R10 stall load", 4'd3, 32'h00000000, '0, 32'h00000001);
    in_valid = 1'b1; in_op = 4'd5; in_a = 32'h00000000;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 hold valid", {31'b0, out_valid}, 32'd1);
      chk("R10 hold data",  out_data, 32'h00000001);
      chk("R10 not ready",  {31'b0, in_ready}, 32'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 waiting taken valid", {31'b0, out_valid}, 32'd1);
    chk("R10 waiting taken data",  out_data, 32'h80000001);
    @(negedge clk);
    chk("R10 drained", {31'b0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ulp();
    t_half();
    t_step_in();
    t_step_out();
    t_directed();
    t_nan();
    t_sign();
    t_reserved();
    t_handshake();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule